// File: doc/BRIEF.md
# PC/PCI DMA Cycle Sequencer

This block turns one granted legacy DMA transfer into two bus cycles on a simple master interface: a memory cycle and an I/O cycle. The requester gives a channel number, a direction, verify and terminal-count flags, and a memory address, all with a one-cycle `req_valid` pulse. The sequencer runs the two cycles in the order the direction calls for. It then reports completion with a `done` pulse.

The I/O cycle goes to one of four fixed addresses, chosen by the verify and terminal-count flags. Its byte enables and data lane follow the channel width. Channels below the cascade channel move bytes; channels above it move 16-bit words. The memory cycle uses the dword-aligned address. Its byte enables mark the lane that the low address bits select. Data moves between the I/O low lane and that memory lane one item per transfer, with no dword packing. A request on the cascade channel is refused with an error pulse. An I/O cycle starts only while the grant qualifier is high. A transfer whose grant is low waits and is not dropped.

Top module: `pcdma_cycle_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `bus_req` are all low.
- R2: A request on channel 4 produces a one-cycle `err` pulse one clock after it is sampled. It produces no bus cycle, and `busy` stays low.
- R3: The kind encoding is `bus_kind` 00 I/O read, 01 I/O write, 10 memory read, 11 memory write.
  - With `req_to_mem`=1 a transfer is an I/O read followed by a memory write.
  - With `req_to_mem`=0 it is a memory read followed by an I/O write.
  - After the second acknowledge, `busy` falls and `done` pulses for one cycle.
- R4: The I/O cycle address depends on the two flags:

  | Verify | Terminal count | Address |
  |--------|----------------|---------|
  | 0 | 0 | 00h |
  | 0 | 1 | 04h |
  | 1 | 0 | C0h |
  | 1 | 1 | C4h |

  The address is zero-extended to the bus width.
- R5: An I/O cycle request rises only in a cycle after `gnt` was sampled high. While `gnt` is low the pending transfer waits with `busy` high and is not dropped.
- R6: I/O byte enables are active low, with bit 0 being data bits 7:0. The value is 1110b on channels 0 to 3 and 1100b on channels 5 to 7. Verify cycles use the same values.
- R7: The memory cycle address is the request address with bits 1:0 cleared. On an 8-bit channel the memory byte enables clear only bit `maddr[1:0]`. On a 16-bit channel they clear bits 1:0 when `maddr[1]`=0 and bits 3:2 otherwise.
- R8: Data moves one item per transfer, with unused lanes zero:
  - On an I/O read to memory, the low byte (8-bit channel) or low halfword (16-bit channel) of the I/O read data is placed at the selected memory lane.
  - On a memory read to I/O, that lane of the memory read data appears on I/O write data bits 7:0 or 15:0.
- R9: `bus_req` stays high, with kind, address, byte enables and write data stable, until `bus_ack` is sampled high. It falls on that edge.
- R10: A `req_valid` pulse while `busy` is high is ignored. The transfer in progress keeps its own cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request pulse |
| req_chan | input | CW | DMA channel number |
| req_to_mem | input | 1 | 1: I/O to memory, 0: memory to I/O |
| req_verify | input | 1 | Verify transfer |
| req_tc | input | 1 | Terminal count reached |
| req_maddr | input | AW | Memory byte address |
| gnt | input | 1 | Grant qualifier for I/O cycles |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse (cascade channel) |
| bus_req | output | 1 | Bus cycle request |
| bus_kind | output | 2 | Cycle kind (see R3) |
| bus_addr | output | AW | Cycle address |
| bus_be_n | output | DW/8 | Active-low byte enables |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Cycle completion from the bus |
| bus_rdata | input | DW | Read data, valid with `bus_ack` |

## Verification
The assertions assume that `bus_ack` is raised only while `bus_req` is high. They also assume that `bus_ack` lasts one cycle, so the acknowledge that ends one cycle is never seen by the next. The bench responder follows both rules. It asserts the acknowledge after a chosen latency from a pending request and clears it on the following cycle. The grant checks take `gnt` as a synchronous input. The bench changes it only between clock edges, either under script or pseudo-randomly, including long low stretches in the middle of a transfer.

// File: rtl/pcdma_pkg.sv
package pcdma_pkg;
  typedef enum logic [1:0] {
    K_IORD  = 2'b00,
    K_IOWR  = 2'b01,
    K_MEMRD = 2'b10,
    K_MEMWR = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;

  typedef struct packed {
    logic to_mem;
    logic verify;
    logic tc;
    logic wide;
  } xfer_ctl_t;

  localparam logic [7:0] IO_NORMAL_BASE = 8'h00;
  localparam logic [7:0] IO_VERIFY_BASE = 8'hC0;
  localparam logic [7:0] IO_TC_OFFSET   = 8'h04;
endpackage

// File: rtl/pcdma_decode.sv
module pcdma_decode #(
  parameter int AW  = 32,
  parameter int NBE = 4,
  localparam int LW = $clog2(NBE)
) (
  input  logic           verify,
  input  logic           tc,
  input  logic           wide,
  input  logic [AW-1:0]  maddr,
  output logic [AW-1:0]  io_addr,
  output logic [NBE-1:0] io_be_n,
  output logic [AW-1:0]  mem_addr,
  output logic [NBE-1:0] mem_be_n,
  output logic [LW-1:0]  lane
);
  import pcdma_pkg::*;

  logic [NBE-1:0] width_mask;

  always_comb begin
    width_mask = wide ? NBE'(3) : NBE'(1);
    lane       = wide ? {maddr[LW-1:1], 1'b0} : maddr[LW-1:0];
    io_addr    = AW'(verify ? IO_VERIFY_BASE : IO_NORMAL_BASE)
               | AW'(tc ? IO_TC_OFFSET : 8'h00);
    io_be_n    = ~width_mask;
    mem_addr   = {maddr[AW-1:LW], LW'(0)};
    mem_be_n   = ~(width_mask << lane);
  end
endmodule

// File: rtl/pcdma_lanes.sv
module pcdma_lanes #(
  parameter int DW = 32,
  localparam int LW = $clog2(DW/8)
) (
  input  logic          wide,
  input  logic [LW-1:0] lane,
  input  logic [DW-1:0] src,
  output logic [DW-1:0] placed,
  output logic [DW-1:0] picked
);
  logic [LW+2:0] shamt;
  logic [DW-1:0] item;
  logic [DW-1:0] mask;

  always_comb begin
    shamt  = {lane, 3'b000};
    mask   = wide ? DW'(16'hFFFF) : DW'(8'hFF);
    item   = src & mask;
    placed = item << shamt;
    picked = (src >> shamt) & mask;
  end
endmodule

// File: rtl/pcdma_cycle_seq.sv
module pcdma_cycle_seq #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int CW         = 3,
  parameter int CASCADE_CH = 4,
  localparam int NBE = DW/8,
  localparam int LW  = $clog2(NBE)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [CW-1:0]  req_chan,
  input  logic           req_to_mem,
  input  logic           req_verify,
  input  logic           req_tc,
  input  logic [AW-1:0]  req_maddr,
  input  logic           gnt,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic           bus_req,
  output logic [1:0]     bus_kind,
  output logic [AW-1:0]  bus_addr,
  output logic [NBE-1:0] bus_be_n,
  output logic [DW-1:0]  bus_wdata,
  input  logic           bus_ack,
  input  logic [DW-1:0]  bus_rdata
);
  import pcdma_pkg::*;

  phase_e    phase;
  xfer_ctl_t ctl;
  logic [AW-1:0]  maddr_q;
  logic [DW-1:0]  data_q;
  kind_e          kind_q;
  kind_e          next_kind;
  logic           next_is_io;
  logic           may_issue;
  logic           req_cascade;

  logic [AW-1:0]  io_addr, mem_addr;
  logic [NBE-1:0] io_be_n, mem_be_n;
  logic [LW-1:0]  lane;
  logic [DW-1:0]  placed, picked;

  pcdma_decode #(.AW(AW), .NBE(NBE)) u_decode (
    .verify  (ctl.verify),
    .tc      (ctl.tc),
    .wide    (ctl.wide),
    .maddr   (maddr_q),
    .io_addr (io_addr),
    .io_be_n (io_be_n),
    .mem_addr(mem_addr),
    .mem_be_n(mem_be_n),
    .lane    (lane)
  );

  pcdma_lanes #(.DW(DW)) u_lanes (
    .wide  (ctl.wide),
    .lane  (lane),
    .src   (data_q),
    .placed(placed),
    .picked(picked)
  );

  always_comb begin
    req_cascade = (req_chan == CW'(CASCADE_CH));
    if (phase == PH_SECOND) next_kind = ctl.to_mem ? K_MEMWR : K_IOWR;
    else                    next_kind = ctl.to_mem ? K_IORD  : K_MEMRD;
    next_is_io = ~next_kind[1];
    may_issue  = ~next_is_io | gnt;
  end

  assign bus_kind = kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      ctl       <= '0;
      maddr_q   <= '0;
      data_q    <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      bus_req   <= 1'b0;
      kind_q    <= K_IORD;
      bus_addr  <= '0;
      bus_be_n  <= '1;
      bus_wdata <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            if (req_cascade) begin
              err <= 1'b1;
            end else begin
              phase      <= PH_FIRST;
              busy       <= 1'b1;
              ctl.to_mem <= req_to_mem;
              ctl.verify <= req_verify;
              ctl.tc     <= req_tc;
              ctl.wide   <= (req_chan > CW'(CASCADE_CH));
              maddr_q    <= req_maddr;
            end
          end
        end
        PH_FIRST, PH_SECOND: begin
          if (!bus_req) begin
            if (may_issue) begin
              bus_req   <= 1'b1;
              kind_q    <= next_kind;
              bus_addr  <= next_is_io ? io_addr : mem_addr;
              bus_be_n  <= next_is_io ? io_be_n : mem_be_n;
              if (phase == PH_FIRST) bus_wdata <= '0;
              else                   bus_wdata <= next_is_io ? picked : placed;
            end
          end else if (bus_ack) begin
            bus_req <= 1'b0;
            if (phase == PH_FIRST) begin
              data_q <= bus_rdata;
              phase  <= PH_SECOND;
            end else begin
              phase <= PH_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcdma_chk.sv
module pcdma_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int NBE = DW/8,
  localparam int LW  = $clog2(NBE)
) (
  input logic           clk,
  input logic           rst,
  input logic           gnt,
  input logic           busy,
  input logic           done,
  input logic           err,
  input logic           bus_req,
  input logic [1:0]     bus_kind,
  input logic [AW-1:0]  bus_addr,
  input logic [NBE-1:0] bus_be_n,
  input logic [DW-1:0]  bus_wdata,
  input logic           bus_ack
);
  a_r5_io_needs_grant: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !$past(bus_req) && !bus_kind[1]) |-> $past(gnt));

  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_kind) && $stable(bus_addr)
                               && $stable(bus_be_n) && $stable(bus_wdata)));

  a_r9_drop_on_ack: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ack) |=> !bus_req);

  a_r2_err_idle: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && !bus_req));

  a_r3_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !bus_req));

  a_r3_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, err}));

  a_r3_req_inside_busy: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> busy);

  a_r6_io_be_width: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_kind[1]) |-> ($countones(~bus_be_n) == 1 || $countones(~bus_be_n) == 2));

  a_r7_mem_aligned: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_kind[1]) |-> (bus_addr[LW-1:0] == '0));
endmodule

bind pcdma_cycle_seq pcdma_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .gnt      (gnt),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .bus_req  (bus_req),
  .bus_kind (bus_kind),
  .bus_addr (bus_addr),
  .bus_be_n (bus_be_n),
  .bus_wdata(bus_wdata),
  .bus_ack  (bus_ack)
);

// File: tb/pcdma_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module pcdma_cycle_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_chan = '0;
  logic        req_to_mem = 1'b0;
  logic        req_verify = 1'b0;
  logic        req_tc = 1'b0;
  logic [31:0] req_maddr = '0;
  logic        gnt = 1'b1;
  logic        busy, done, err, bus_req;
  logic [1:0]  bus_kind;
  logic [31:0] bus_addr;
  logic [3:0]  bus_be_n;
  logic [31:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  int checks = 0;
  int errors = 0;
  int ack_lat = 0;
  int wcnt = 0;
  int seq = 0;
  bit gnt_auto = 1'b0;
  string ctx = "main";

  always #2.5 clk = ~clk;

  pcdma_cycle_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
    .req_to_mem(req_to_mem), .req_verify(req_verify), .req_tc(req_tc),
    .req_maddr(req_maddr), .gnt(gnt), .busy(busy), .done(done), .err(err),
    .bus_req(bus_req), .bus_kind(bus_kind), .bus_addr(bus_addr),
    .bus_be_n(bus_be_n), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%h expected=%h at %0t", tag, ctx, act, exp, $time);
    end
  endtask

  // Expected-value helpers derived from the requirements
  function automatic logic [31:0] exp_io_addr(input bit ver, input bit tc);
    return 32'((ver ? 192 : 0) + (tc ? 4 : 0));          // R4
  endfunction

  function automatic logic [3:0] exp_io_be(input bit wide);
    return wide ? 4'b1100 : 4'b1110;                      // R6
  endfunction

  function automatic int lane_of(input bit wide, input logic [31:0] ma);
    int l;
    l = int'(ma % 4);
    if (wide) l = (l / 2) * 2;
    return l;
  endfunction

  function automatic logic [3:0] exp_mem_be(input bit wide, input logic [31:0] ma);
    int l;
    logic [3:0] en;
    l  = lane_of(wide, ma);
    en = '0;
    en[l] = 1'b1;
    if (wide) en[l+1] = 1'b1;
    return ~en;                                           // R7
  endfunction

  function automatic logic [31:0] exp_place(input bit wide, input logic [31:0] ma, input logic [31:0] d);
    logic [31:0] it;
    it = wide ? (d % 32'h10000) : (d % 32'h100);
    return it * (32'h1 << (8 * lane_of(wide, ma)));       // R8
  endfunction

  function automatic logic [31:0] exp_pick(input bit wide, input logic [31:0] ma, input logic [31:0] d);
    logic [31:0] sh;
    sh = d / (32'h1 << (8 * lane_of(wide, ma)));
    return wide ? (sh % 32'h10000) : (sh % 32'h100);      // R8
  endfunction

  // Behavioural reference model, advanced on every rising edge
  int          m_ph = 0;
  bit          m_busy = 0, m_done = 0, m_err = 0, m_req = 0;
  logic [1:0]  m_kind = '0;
  logic [31:0] m_addr = '0, m_wd = '0, l_ma = '0, l_data = '0;
  logic [3:0]  m_be = '1;
  bit          l_tomem = 0, l_ver = 0, l_tc = 0, l_wide = 0;

  always @(posedge clk) begin
    logic [1:0] k;
    if (rst) begin
      m_ph <= 0; m_busy <= 0; m_done <= 0; m_err <= 0; m_req <= 0;
    end else begin
      m_done <= 0;
      m_err  <= 0;
      if (m_ph == 0) begin
        if (req_valid) begin
          if (req_chan == 3'd4) m_err <= 1;
          else begin
            m_ph <= 1; m_busy <= 1;
            l_tomem <= req_to_mem; l_ver <= req_verify; l_tc <= req_tc;
            l_wide <= (req_chan >= 3'd5); l_ma <= req_maddr;
          end
        end
      end else if (!m_req) begin
        if (m_ph == 1) k = l_tomem ? 2'b00 : 2'b10;
        else           k = l_tomem ? 2'b11 : 2'b01;
        if (k[1] || gnt) begin
          m_req  <= 1;
          m_kind <= k;
          m_addr <= k[1] ? {l_ma[31:2], 2'b00} : exp_io_addr(l_ver, l_tc);
          m_be   <= k[1] ? exp_mem_be(l_wide, l_ma) : exp_io_be(l_wide);
          m_wd   <= (k == 2'b11) ? exp_place(l_wide, l_ma, l_data)
                  : (k == 2'b01) ? exp_pick(l_wide, l_ma, l_data) : 32'h0;
        end
      end else if (bus_ack) begin
        m_req <= 0;
        if (m_ph == 1) begin l_data <= bus_rdata; m_ph <= 2; end
        else begin m_ph <= 0; m_busy <= 0; m_done <= 1; end
      end
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(busy == m_busy, "R3 busy", 32'(busy), 32'(m_busy));
      chk(done == m_done, "R3 done", 32'(done), 32'(m_done));
      chk(err == m_err,   "R2 err",  32'(err),  32'(m_err));
      chk(bus_req == m_req, "R5/R9 bus_req", 32'(bus_req), 32'(m_req));
      if (bus_req && m_req) begin
        chk(bus_kind == m_kind, "R3 kind", 32'(bus_kind), 32'(m_kind));
        chk(bus_addr == m_addr, m_kind[1] ? "R7 mem addr" : "R4 io addr", bus_addr, m_addr);
        chk(bus_be_n == m_be,   m_kind[1] ? "R7 mem be"   : "R6 io be", 32'(bus_be_n), 32'(m_be));
        if (m_kind[0]) chk(bus_wdata == m_wd, "R8 wdata", bus_wdata, m_wd);
      end
    end
  end

  // Bus responder: one-cycle acknowledge after ack_lat idle cycles
  always @(negedge clk) begin
    if (rst) begin
      bus_ack = 1'b0; wcnt = 0;
    end else if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_req) begin
      if (wcnt >= ack_lat) begin
        seq++;
        bus_ack   = 1'b1;
        bus_rdata = 32'h8C3A_51E7 ^ (32'(seq) * 32'h0106_0B11);
        wcnt      = 0;
      end else wcnt++;
    end
    if (gnt_auto) gnt = ($urandom % 4) != 0;
  end

  task automatic start(input int ch, input bit tomem, input bit ver, input bit tc, input logic [31:0] ma);
    @(negedge clk);
    req_valid = 1'b1; req_chan = 3'(ch); req_to_mem = tomem;
    req_verify = ver; req_tc = tc; req_maddr = ma;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 400 && busy; n++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input int ch, input bit tomem, input bit ver, input bit tc, input logic [31:0] ma);
    start(ch, tomem, ver, tc, ma);
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R3 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    ctx = "R1";
    chk(!busy && !done && !err && !bus_req, "R1 reset outputs",
        {28'b0, busy, done, err, bus_req}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !bus_req, "R1 after release", {30'b0, busy, bus_req}, 32'h0);

    ctx = "directed";
    xfer(0, 1, 0, 0, 32'h1000_0003);   // R3 R8 io read -> mem write, lane 3
    xfer(2, 0, 0, 1, 32'h2000_0101);   // R4 04h, R7 lane 1
    ack_lat = 2;
    xfer(5, 1, 1, 0, 32'h3000_0012);   // R4 C0h, R6 1100b, lane 2
    xfer(7, 0, 1, 1, 32'h4000_0003);   // R4 C4h, R7 wide lane rounds to 2
    xfer(6, 0, 0, 0, 32'h5000_0001);   // R7 wide lane 0

    ctx = "R2";
    start(4, 1, 0, 0, 32'h6000_0000);
    chk(err && !busy && !bus_req, "R2 cascade refused",
        {29'b0, err, busy, bus_req}, 32'h4);
    repeat (4) @(negedge clk);
    chk(!busy && !bus_req, "R2 no cycle", {30'b0, busy, bus_req}, 32'h0);

    ctx = "R5";
    gnt = 1'b0;
    start(1, 1, 0, 0, 32'h7000_0002);
    repeat (12) @(negedge clk);
    chk(busy && !bus_req, "R5 waits without grant", {30'b0, busy, bus_req}, 32'h2);
    gnt = 1'b1;
    wait_idle();
    ack_lat = 3;
    start(6, 0, 0, 1, 32'h7100_0002);
    for (int n = 0; n < 20 && !bus_req; n++) @(negedge clk);
    gnt = 1'b0;
    repeat (15) @(negedge clk);
    chk(busy && !bus_req, "R5 io write held off", {30'b0, busy, bus_req}, 32'h2);
    gnt = 1'b1;
    wait_idle();

    ctx = "R10";
    ack_lat = 1;
    start(3, 0, 0, 0, 32'h8000_0002);
    @(negedge clk);
    req_valid = 1'b1; req_chan = 3'd5; req_to_mem = 1'b1; req_verify = 1'b1;
    req_tc = 1'b1; req_maddr = 32'h9999_9999;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();   // model ignores the second pulse; cycles compared per clock

    ctx = "mixed";
    gnt_auto = 1'b1;
    for (int i = 0; i < 40; i++) begin
      ack_lat = i % 4;
      xfer(i % 8, (i / 3) % 2 == 0, (i / 5) % 2 == 1, (i / 2) % 2 == 1,
           32'h0A00_0000 + 32'(i * 37));
    end
    gnt_auto = 1'b0;
    gnt = 1'b1;
    repeat (4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule